// File: doc/BRIEF.md
# Interrupt Request Gate

This block sits beside a 32-bit processor's control coprocessor. It holds a reduced status word, a cause word and one per-thread exemption bit. In every cycle it decides whether a hardware interrupt may be taken, and it presents that decision as a single registered request line to the exception sequencer.

The block grants a request only when two conditions hold together. First, the global enable allows it. Second, some pending line is unmasked. Interrupts are allowed when all of the following are true: global enable is set, the exception level is clear, the error level is clear, debug mode is off, and the thread is not exempt.

The eight pending bits and the eight mask bits are read in one of two ways:
- **Per-line mode** (vectored-controller configuration low): each mask bit gates its own pending line.
- **Vectored-controller mode** (configuration high): an external vectoring controller supplies a numeric request code, and the mask bits form a priority level that the code must strictly exceed.

There is no data stream here. All pins are plain control and status signals, so no valid/ready handshake or back-pressure applies.

Top module: `irq_gate_unit`

## Requirements
- R1: After synchronous reset `irq_req` is 0, the status word is 0x0000_FF04 (error level set, global enable clear, all mask bits set), the cause word is 0 and the exemption bit is 0. No request rises until software clears the error level, even when a pending line is unmasked.
- R2: A request is allowed only when status bit 0 (global enable) is 1, status bit 1 (exception level) is 0 and status bit 2 (error level) is 0.
- R3: While `dbg_mode` is 1, `irq_req` is 0 from the next clock edge on.
- R4: Bit 10 of the thread-status word is the exemption bit. While it is 1, no request is raised.
- R5: With `vec_ctrl_cfg` = 0, an interrupt is pending when cause[15:8] AND status[15:8] is nonzero.
- R6: With `vec_ctrl_cfg` = 1, an interrupt is pending only when cause[15:8], taken as an unsigned number, is strictly greater than status[15:8]. Equal values do not count as pending.
- R7: A write strobe updates its register at the clock edge where it is sampled. Writes to status and cause in the same cycle are both applied.
- R8: `irq_req` is the AND of allowed and pending, registered on the rising edge. It therefore follows a register write by two edges and a change of `dbg_mode` or `vec_ctrl_cfg` by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_data | input | 32 | Status write value |
| cause_wr_en | input | 1 | Cause write strobe |
| cause_wr_data | input | 32 | Cause write value |
| thr_wr_en | input | 1 | Thread-status write strobe |
| thr_wr_data | input | 32 | Thread-status write value (bit 10 = exemption) |
| dbg_mode | input | 1 | Debug mode active |
| vec_ctrl_cfg | input | 1 | Vectored external controller configured |
| irq_req | output | 1 | Registered interrupt request |

## Verification
Each stored bit reaches the ports only through `irq_req`. A wrong status, cause or exemption value therefore shows up as a missing or false request exactly two edges after the write that should have set it. A wrong gate or compare term in the combinational path shows up one edge after the input that exercises it. The directed cases are chosen so that per-line mode and level mode give opposite answers on the same field values, and so that pending equal to the level is exercised. This exposes a swapped mode, a swapped comparison, or a compare that is signed or non-strict.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LINES      = 8;
  localparam int unsigned FIELD_LSB  = 8;
  localparam int unsigned FIELD_MSB  = FIELD_LSB + LINES - 1;
  localparam int unsigned IE_POS     = 0;
  localparam int unsigned EXL_POS    = 1;
  localparam int unsigned ERL_POS    = 2;
  localparam int unsigned EXEMPT_POS = 10;
  localparam logic [WORD_W-1:0] STATUS_RST = 32'h0000_FF04;

  typedef struct packed {
    logic ie;
    logic exl;
    logic erl;
  } gate_bits_t;
endpackage

// File: rtl/irq_csr_regs.sv
module irq_csr_regs
  import irq_gate_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter int unsigned XPOS = EXEMPT_POS,
  parameter logic [W-1:0] ST_RST = STATUS_RST
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stat_we,
  input  logic [W-1:0] stat_wd,
  input  logic         cause_we,
  input  logic [W-1:0] cause_wd,
  input  logic         thr_we,
  input  logic [W-1:0] thr_wd,
  output logic [W-1:0] status_q,
  output logic [W-1:0] cause_q,
  output logic         exempt_q
);
  logic unused_thr;
  assign unused_thr = ^{thr_wd[W-1:XPOS+1], thr_wd[XPOS-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= ST_RST;
      cause_q  <= '0;
      exempt_q <= 1'b0;
    end else begin
      if (stat_we)  status_q <= stat_wd;
      if (cause_we) cause_q  <= cause_wd;
      if (thr_we)   exempt_q <= thr_wd[XPOS];
    end
  end
endmodule

// File: rtl/irq_enable_logic.sv
module irq_enable_logic
  import irq_gate_pkg::*;
(
  input  gate_bits_t gates,
  input  logic       dbg,
  input  logic       exempt,
  output logic       allowed
);
  always_comb begin
    allowed = gates.ie;
    if (gates.exl || gates.erl) allowed = 1'b0;
    if (dbg || exempt)          allowed = 1'b0;
  end
endmodule

// File: rtl/irq_pending_eval.sv
module irq_pending_eval #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] mask,
  input  logic         level_mode,
  output logic         hit
);
  logic [N-1:0] line_hit;
  for (genvar i = 0; i < N; i++) begin : g_line
    assign line_hit[i] = pend[i] & mask[i];
  end

  logic any_line;
  logic above_level;
  assign any_line    = |line_hit;
  assign above_level = pend > mask;
  assign hit         = level_mode ? above_level : any_line;
endmodule

// File: rtl/irq_gate_unit.sv
module irq_gate_unit
  import irq_gate_pkg::*;
#(
  parameter int unsigned W   = WORD_W,
  parameter int unsigned N   = LINES,
  parameter int unsigned LSB = FIELD_LSB
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stat_wr_en,
  input  logic [W-1:0] stat_wr_data,
  input  logic         cause_wr_en,
  input  logic [W-1:0] cause_wr_data,
  input  logic         thr_wr_en,
  input  logic [W-1:0] thr_wr_data,
  input  logic         dbg_mode,
  input  logic         vec_ctrl_cfg,
  output logic         irq_req
);
  localparam int unsigned MSB = LSB + N - 1;

  logic [W-1:0] status_q;
  logic [W-1:0] cause_q;
  logic         exempt_q;
  logic         allowed;
  logic         pending;
  gate_bits_t   gates;

  irq_csr_regs #(.W(W), .XPOS(EXEMPT_POS), .ST_RST(W'(STATUS_RST))) u_regs (
    .clk(clk), .rst(rst),
    .stat_we(stat_wr_en), .stat_wd(stat_wr_data),
    .cause_we(cause_wr_en), .cause_wd(cause_wr_data),
    .thr_we(thr_wr_en), .thr_wd(thr_wr_data),
    .status_q(status_q), .cause_q(cause_q), .exempt_q(exempt_q)
  );

  assign gates.ie  = status_q[IE_POS];
  assign gates.exl = status_q[EXL_POS];
  assign gates.erl = status_q[ERL_POS];

  irq_enable_logic u_enable (
    .gates(gates), .dbg(dbg_mode), .exempt(exempt_q), .allowed(allowed)
  );

  irq_pending_eval #(.N(N)) u_pend (
    .pend(cause_q[MSB:LSB]), .mask(status_q[MSB:LSB]),
    .level_mode(vec_ctrl_cfg), .hit(pending)
  );

  logic unused_bits;
  assign unused_bits = ^{status_q[W-1:MSB+1], status_q[LSB-1:ERL_POS+1],
                         cause_q[W-1:MSB+1], cause_q[LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= allowed & pending;
  end
endmodule

// File: rtl/irq_gate_checks.sv
module irq_gate_checks (
  input logic        clk,
  input logic        rst,
  input logic        dbg_mode,
  input logic        vec_ctrl_cfg,
  input logic        stat_wr_en,
  input logic [31:0] stat_wr_data,
  input logic [31:0] status_q,
  input logic [31:0] cause_q,
  input logic        exempt_q,
  input logic        irq_req
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) assert_reset_quiet_R1: assert (!irq_req);
  end

  assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (status_q[2] || status_q[1] || !status_q[0]) |=> !irq_req);

  assert_debug_R3: assert property (@(posedge clk) disable iff (rst)
    dbg_mode |=> !irq_req);

  assert_exempt_R4: assert property (@(posedge clk) disable iff (rst)
    exempt_q |=> !irq_req);

  assert_level_R6: assert property (@(posedge clk) disable iff (rst)
    (vec_ctrl_cfg && (cause_q[15:8] <= status_q[15:8])) |=> !irq_req);

  assert_write_R7: assert property (@(posedge clk) disable iff (rst)
    stat_wr_en |=> (status_q == $past(stat_wr_data)));
endmodule

bind irq_gate_unit irq_gate_checks u_checks (
  .clk(clk), .rst(rst), .dbg_mode(dbg_mode), .vec_ctrl_cfg(vec_ctrl_cfg),
  .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
  .status_q(status_q), .cause_q(cause_q), .exempt_q(exempt_q),
  .irq_req(irq_req)
);

// File: tb/irq_gate_unit_test.sv
`timescale 1ns/1ps
module irq_gate_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stat_wr_en = 1'b0, cause_wr_en = 1'b0, thr_wr_en = 1'b0;
  logic [31:0] stat_wr_data = '0, cause_wr_data = '0, thr_wr_data = '0;
  logic        dbg_mode = 1'b0, vec_ctrl_cfg = 1'b0;
  logic        irq_req;
  int          n_checks = 0, n_errors = 0;

  always #2 clk = ~clk;

  irq_gate_unit uut (
    .clk(clk), .rst(rst),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
    .cause_wr_en(cause_wr_en), .cause_wr_data(cause_wr_data),
    .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
    .dbg_mode(dbg_mode), .vec_ctrl_cfg(vec_ctrl_cfg), .irq_req(irq_req)
  );

  function automatic logic [31:0] st(input logic [7:0] m, input logic erl,
                                     input logic exl, input logic ie);
    return {16'h0, m, 5'b0, erl, exl, ie};
  endfunction

  function automatic logic [31:0] ca(input logic [7:0] p);
    return {16'h0, p, 8'h0};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: irq_req=%b expected %b", req, act, exp);
    end
  endtask

  // One-cycle strobes, driven on the falling edge.
  task automatic wr_stat(input logic [31:0] d);
    @(negedge clk); stat_wr_en = 1'b1; stat_wr_data = d;
    @(negedge clk); stat_wr_en = 1'b0;
  endtask
  task automatic wr_cause(input logic [31:0] d);
    @(negedge clk); cause_wr_en = 1'b1; cause_wr_data = d;
    @(negedge clk); cause_wr_en = 1'b0;
  endtask
  task automatic wr_thr(input logic [31:0] d);
    @(negedge clk); thr_wr_en = 1'b1; thr_wr_data = d;
    @(negedge clk); thr_wr_en = 1'b0;
  endtask
  // Registers updated; one more edge for the request flop.
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset", irq_req, 1'b0);
    wr_cause(ca(8'h01)); settle();
    check("R1 error level holds off request", irq_req, 1'b0);
  endtask

  task automatic t_gates();
    wr_stat(st(8'hFF, 0, 0, 1)); settle();
    check("R2 all gates open", irq_req, 1'b1);
    wr_stat(st(8'hFF, 0, 0, 0)); settle();
    check("R2 global enable clear", irq_req, 1'b0);
    wr_stat(st(8'hFF, 0, 1, 1)); settle();
    check("R2 exception level set", irq_req, 1'b0);
    wr_stat(st(8'hFF, 1, 0, 1)); settle();
    check("R2 error level set", irq_req, 1'b0);
  endtask

  task automatic t_line_mode();
    vec_ctrl_cfg = 1'b0;
    wr_stat(st(8'h0F, 0, 0, 1)); wr_cause(ca(8'hF0)); settle();
    check("R5 disjoint mask", irq_req, 1'b0);
    wr_cause(ca(8'h10)); wr_stat(st(8'h10, 0, 0, 1)); settle();
    check("R5 single line hit", irq_req, 1'b1);
    wr_stat(st(8'h03, 0, 0, 1)); wr_cause(ca(8'h01)); settle();
    check("R5 low pend under level still hits", irq_req, 1'b1);
  endtask

  task automatic t_level_mode();
    @(negedge clk); vec_ctrl_cfg = 1'b1; @(negedge clk);
    check("R6 pend 1 below level 3", irq_req, 1'b0);
    wr_stat(st(8'h05, 0, 0, 1)); wr_cause(ca(8'h05)); settle();
    check("R6 pend equal level", irq_req, 1'b0);
    wr_cause(ca(8'h06)); settle();
    check("R6 pend above level", irq_req, 1'b1);
    wr_stat(st(8'h7F, 0, 0, 1)); wr_cause(ca(8'h80)); settle();
    check("R6 unsigned compare 0x80>0x7F", irq_req, 1'b1);
    @(negedge clk); vec_ctrl_cfg = 1'b0; @(negedge clk);
    check("R8 mode flip one edge, per-line gives 0", irq_req, 1'b0);
  endtask

  task automatic t_debug();
    wr_stat(st(8'h01, 0, 0, 1)); wr_cause(ca(8'h01)); settle();
    check("R3 baseline", irq_req, 1'b1);
    @(negedge clk); dbg_mode = 1'b1; @(negedge clk);
    check("R3 debug blocks", irq_req, 1'b0);
    dbg_mode = 1'b0; @(negedge clk);
    check("R3 debug released", irq_req, 1'b1);
  endtask

  task automatic t_exempt();
    wr_thr(32'h0000_0400); settle();
    check("R4 exempt blocks", irq_req, 1'b0);
    wr_thr(32'hFFFF_FBFF); settle();
    check("R4 exempt cleared, other bits ignored", irq_req, 1'b1);
  endtask

  task automatic t_simul();
    wr_stat(st(8'h00, 0, 0, 0)); wr_cause(ca(8'h00)); settle();
    check("R7 precondition", irq_req, 1'b0);
    @(negedge clk);
    stat_wr_en = 1'b1; stat_wr_data = st(8'h02, 0, 0, 1);
    cause_wr_en = 1'b1; cause_wr_data = ca(8'h02);
    @(negedge clk);
    stat_wr_en = 1'b0; cause_wr_en = 1'b0;
    check("R8 request not yet after one edge", irq_req, 1'b0);
    @(negedge clk);
    check("R7 both writes applied", irq_req, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gates();
    t_line_mode();
    t_level_mode();
    t_debug();
    t_exempt();
    t_simul();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #100000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule